// File: doc/BRIEF.md
# Dual-Input Supply Source Selector

This controller decides which external supply feeds a system power rail: a wide-range DC adapter input, a USB input, or neither (the battery carries the rail alone). It receives the two input voltages as digitized millivolt codes on a fixed sampling clock, along with a DC limit-mode pin, a USB limit-select pin, a programmed DC limit value, a suspend request and a die temperature code in degrees Celsius.

Each input is checked against a voltage window and then debounced, so that a reading hovering near a threshold cannot make the selection chatter. The DC window's lower edge is raised while USB is qualified, which keeps handovers between the two supplies clean. DC always wins over USB. The block drives a one-hot source select and a current-limit setpoint in milliamps. The setpoint slews at a fixed step per clock, is reduced linearly at high die temperature, and must reach zero before the selection moves off an active source.

Top module: `supply_source_sel`

## Requirements
- R1: `usb_ok` is 1 only while the USB reading is strictly between 4100 mV and 6600 mV. The flag takes a new value only after DEB_LEN consecutive samples that disagree with its present value. It updates on the DEB_LEN-th such clock edge, and a shorter excursion leaves it unchanged.
- R2: `dc_ok` uses the same debounce as R1, on the window of strictly above 4150 mV and strictly below 16000 mV. While `usb_ok` is 1, the lower edge becomes 4450 mV.
- R3: `src_sel` is one-hot: bit 0 = battery only, bit 1 = USB, bit 2 = DC. The requested source is DC when `dc_ok` is 1, otherwise USB when `usb_ok` is 1, otherwise battery. With both flags set, DC is selected.
- R4: Whenever `src_sel` indicates battery only, `ilim_ma` is 0.
- R5: Toward a higher target, `ilim_ma` rises by at most RAMP_STEP per clock, where RAMP_STEP = ceil(2000 / (CLK_MHZ*RAMP_US)). It settles exactly on the target.
- R6: When the requested source differs from an active (non-battery) selection, the limit ramps down to 0 first. `src_sel` changes only on an edge at which `ilim_ma` was already 0. After the change, the limit ramps up from 0.
- R7: The target with DC selected is as follows. With `dc_prog_mode`=0, it is 500 mA if `usb_lim_hi`=1 and 100 mA if `usb_lim_hi`=0. With `dc_prog_mode`=1, it is `prog_lim_ma` clamped to 500..2000 mA. With USB selected, it is 500 or 100 mA according to `usb_lim_hi`.
- R8: While `suspend` is 1, the next clock edge sets `ilim_ma` to 0 and `src_sel` to battery only. During suspend, `usb_ok` and `dc_ok` keep tracking their inputs.
- R9: For a die temperature T with 100 < T < 120, the target is floor(base × (100 − 5·(T−100)) / 100). For T ≤ 100 the target is the base value. For T ≥ 120, `ilim_ma` is 0 on the next edge.
- R10: After reset: `dc_ok`=0, `usb_ok`=0, `src_sel`=3'b001, `ilim_ma`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_mv | input | MV_W | DC adapter input voltage, millivolts |
| usb_mv | input | MV_W | USB input voltage, millivolts |
| dc_prog_mode | input | 1 | 1: DC limit taken from `prog_lim_ma`; 0: USB-style 100/500 mA |
| usb_lim_hi | input | 1 | 1: 500 mA class, 0: 100 mA class |
| prog_lim_ma | input | LIM_W | Programmed DC limit, milliamps |
| suspend | input | 1 | Suspend request: rail off, limit zero |
| die_temp_c | input | TEMP_W | Die temperature, degrees Celsius, unsigned |
| dc_ok | output | 1 | Debounced DC valid flag |
| usb_ok | output | 1 | Debounced USB valid flag |
| src_sel | output | 3 | One-hot source select {DC, USB, battery} |
| ilim_ma | output | LIM_W | Ramped current-limit setpoint, milliamps |

## Verification
The bench builds the block with DEB_LEN = 4, CLK_MHZ = 1 and RAMP_US = 50. A four-sample debounce makes the exact update edge and a rejected two-sample glitch cheap to observe. A 40 mA ramp step brings a full 0 to 2000 mA slew, and the drain before a USB-to-DC handover, within about fifty clocks, so every takeover, derating level and the suspend recovery can be run to completion. Threshold cases sit exactly on and one code past the window edges, including the raised DC lower edge while USB is present.

// File: rtl/srcsel_pkg.sv
package srcsel_pkg;
  typedef enum logic [2:0] {
    SRC_BAT = 3'b001,
    SRC_USB = 3'b010,
    SRC_DC  = 3'b100
  } src_e;
endpackage

// File: rtl/srcsel_chan_qual.sv
// Window compare followed by an agreement debounce for one input.
module srcsel_chan_qual #(
  parameter int MV_W    = 16,
  parameter int DEB_LEN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MV_W-1:0] mv,
  input  logic [MV_W-1:0] lo_mv,
  input  logic [MV_W-1:0] hi_mv,
  output logic            ok
);
  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_LEN - 1);

  logic             in_window;
  logic [CNT_W-1:0] agree_cnt;

  assign in_window = (mv > lo_mv) && (mv < hi_mv);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok        <= 1'b0;
      agree_cnt <= '0;
    end else if (in_window == ok) begin
      agree_cnt <= '0;
    end else if (agree_cnt == LAST) begin
      ok        <= in_window;
      agree_cnt <= '0;
    end else begin
      agree_cnt <= agree_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srcsel_limit_calc.sv
// Base limit for the effective source, then linear thermal derating.
module srcsel_limit_calc
  import srcsel_pkg::*;
#(
  parameter int LIM_W        = 12,
  parameter int TEMP_W       = 8,
  parameter int LIM_LOW_MA   = 100,
  parameter int LIM_HIGH_MA  = 500,
  parameter int PROG_MIN_MA  = 500,
  parameter int FULL_MA      = 2000,
  parameter int HOT_START_C  = 100,
  parameter int PCT_PER_C    = 5
) (
  input  src_e              src,
  input  logic              dc_prog_mode,
  input  logic              usb_lim_hi,
  input  logic [LIM_W-1:0]  prog_lim_ma,
  input  logic [TEMP_W-1:0] die_temp_c,
  output logic [LIM_W-1:0]  tgt_ma,
  output logic              hot_off
);
  localparam int HOT_END_C = HOT_START_C + (100 + PCT_PER_C - 1) / PCT_PER_C;
  localparam int PROD_W    = LIM_W + 8;
  localparam logic [TEMP_W-1:0] T_START = TEMP_W'(HOT_START_C);
  localparam logic [TEMP_W-1:0] T_END   = TEMP_W'(HOT_END_C);
  localparam logic [LIM_W-1:0] L_LOW  = LIM_W'(LIM_LOW_MA);
  localparam logic [LIM_W-1:0] L_HIGH = LIM_W'(LIM_HIGH_MA);
  localparam logic [LIM_W-1:0] L_PMIN = LIM_W'(PROG_MIN_MA);
  localparam logic [LIM_W-1:0] L_FULL = LIM_W'(FULL_MA);

  logic [LIM_W-1:0]  usb_class;
  logic [LIM_W-1:0]  prog_clamped;
  logic [LIM_W-1:0]  base_ma;
  logic [7:0]        keep_pct;
  logic [PROD_W-1:0] scaled;

  always_comb begin
    usb_class = usb_lim_hi ? L_HIGH : L_LOW;
    if (prog_lim_ma < L_PMIN)      prog_clamped = L_PMIN;
    else if (prog_lim_ma > L_FULL) prog_clamped = L_FULL;
    else                           prog_clamped = prog_lim_ma;

    unique case (src)
      SRC_DC:  base_ma = dc_prog_mode ? prog_clamped : usb_class;
      SRC_USB: base_ma = usb_class;
      default: base_ma = '0;
    endcase
  end

  always_comb begin
    hot_off = (die_temp_c >= T_END);
    if (die_temp_c <= T_START) keep_pct = 8'd100;
    else if (hot_off)          keep_pct = 8'd0;
    else keep_pct = 8'(100 - PCT_PER_C * (int'(die_temp_c) - HOT_START_C));
    scaled = (PROD_W'(base_ma) * PROD_W'(keep_pct)) / PROD_W'(100);
    tgt_ma = scaled[LIM_W-1:0];
  end
endmodule

// File: rtl/srcsel_ramp.sv
// Slews the setpoint toward the target by a fixed step per clock.
module srcsel_ramp #(
  parameter int LIM_W = 12,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [LIM_W-1:0] tgt_ma,
  output logic [LIM_W-1:0] lvl_ma
);
  localparam logic [LIM_W:0]   STEP_WIDE = (LIM_W+1)'(STEP);
  localparam logic [LIM_W-1:0] STEP_V    = LIM_W'(STEP);

  logic [LIM_W:0]   up_sum;
  logic [LIM_W-1:0] gap_dn;

  assign up_sum = {1'b0, lvl_ma} + STEP_WIDE;
  assign gap_dn = lvl_ma - tgt_ma;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lvl_ma <= '0;
    end else if (lvl_ma < tgt_ma) begin
      lvl_ma <= (up_sum >= {1'b0, tgt_ma}) ? tgt_ma : up_sum[LIM_W-1:0];
    end else if (lvl_ma > tgt_ma) begin
      lvl_ma <= (gap_dn <= STEP_V) ? tgt_ma : (lvl_ma - STEP_V);
    end
  end
endmodule

// File: rtl/supply_source_sel.sv
module supply_source_sel
  import srcsel_pkg::*;
#(
  parameter int MV_W          = 16,
  parameter int LIM_W         = 12,
  parameter int TEMP_W        = 8,
  parameter int DEB_LEN       = 8,
  parameter int CLK_MHZ       = 10,
  parameter int RAMP_US       = 50,
  parameter int DC_LO_MV      = 4150,
  parameter int DC_LO_DUAL_MV = 4450,
  parameter int DC_HI_MV      = 16000,
  parameter int USB_LO_MV     = 4100,
  parameter int USB_HI_MV     = 6600,
  parameter int LIM_LOW_MA    = 100,
  parameter int LIM_HIGH_MA   = 500,
  parameter int PROG_MIN_MA   = 500,
  parameter int FULL_MA       = 2000,
  parameter int HOT_START_C   = 100,
  parameter int PCT_PER_C     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MV_W-1:0]   dc_mv,
  input  logic [MV_W-1:0]   usb_mv,
  input  logic              dc_prog_mode,
  input  logic              usb_lim_hi,
  input  logic [LIM_W-1:0]  prog_lim_ma,
  input  logic              suspend,
  input  logic [TEMP_W-1:0] die_temp_c,
  output logic              dc_ok,
  output logic              usb_ok,
  output logic [2:0]        src_sel,
  output logic [LIM_W-1:0]  ilim_ma
);
  localparam int RAMP_CYC  = (CLK_MHZ * RAMP_US < 1) ? 1 : CLK_MHZ * RAMP_US;
  localparam int RAMP_RAW  = (FULL_MA + RAMP_CYC - 1) / RAMP_CYC;
  localparam int RAMP_STEP = (RAMP_RAW < 1) ? 1 : RAMP_RAW;
  localparam int N_CH      = 2;
  localparam int CH_DC     = 0;
  localparam int CH_USB    = 1;

  logic [MV_W-1:0] ch_mv [N_CH];
  logic [MV_W-1:0] ch_lo [N_CH];
  logic [MV_W-1:0] ch_hi [N_CH];
  logic [N_CH-1:0] ch_ok;

  always_comb begin
    ch_mv[CH_DC]  = dc_mv;
    ch_lo[CH_DC]  = ch_ok[CH_USB] ? MV_W'(DC_LO_DUAL_MV) : MV_W'(DC_LO_MV);
    ch_hi[CH_DC]  = MV_W'(DC_HI_MV);
    ch_mv[CH_USB] = usb_mv;
    ch_lo[CH_USB] = MV_W'(USB_LO_MV);
    ch_hi[CH_USB] = MV_W'(USB_HI_MV);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    srcsel_chan_qual #(
      .MV_W   (MV_W),
      .DEB_LEN(DEB_LEN)
    ) u_qual (
      .clk  (clk),
      .rst  (rst),
      .mv   (ch_mv[c]),
      .lo_mv(ch_lo[c]),
      .hi_mv(ch_hi[c]),
      .ok   (ch_ok[c])
    );
  end

  assign dc_ok  = ch_ok[CH_DC];
  assign usb_ok = ch_ok[CH_USB];

  // Arbitration: requested source vs. the one in service.
  src_e want_src, cur_src, eff_src;
  logic [LIM_W-1:0] tgt_ma;
  logic             hot_off;
  logic             ramp_clr;

  always_comb begin
    if (ch_ok[CH_DC])       want_src = SRC_DC;
    else if (ch_ok[CH_USB]) want_src = SRC_USB;
    else                    want_src = SRC_BAT;
    // While a change is pending, aim the ramp at zero.
    eff_src  = (want_src == cur_src) ? cur_src : SRC_BAT;
    ramp_clr = suspend || hot_off;
  end

  always_ff @(posedge clk) begin
    if (rst || suspend) begin
      cur_src <= SRC_BAT;
    end else if (want_src != cur_src && (cur_src == SRC_BAT || ilim_ma == '0)) begin
      cur_src <= want_src;
    end
  end

  srcsel_limit_calc #(
    .LIM_W      (LIM_W),
    .TEMP_W     (TEMP_W),
    .LIM_LOW_MA (LIM_LOW_MA),
    .LIM_HIGH_MA(LIM_HIGH_MA),
    .PROG_MIN_MA(PROG_MIN_MA),
    .FULL_MA    (FULL_MA),
    .HOT_START_C(HOT_START_C),
    .PCT_PER_C  (PCT_PER_C)
  ) u_calc (
    .src         (eff_src),
    .dc_prog_mode(dc_prog_mode),
    .usb_lim_hi  (usb_lim_hi),
    .prog_lim_ma (prog_lim_ma),
    .die_temp_c  (die_temp_c),
    .tgt_ma      (tgt_ma),
    .hot_off     (hot_off)
  );

  srcsel_ramp #(
    .LIM_W(LIM_W),
    .STEP (RAMP_STEP)
  ) u_ramp (
    .clk   (clk),
    .rst   (rst),
    .clr   (ramp_clr),
    .tgt_ma(tgt_ma),
    .lvl_ma(ilim_ma)
  );

  assign src_sel = cur_src;
endmodule

// File: rtl/srcsel_checker.sv
module srcsel_checker #(
  parameter int LIM_W       = 12,
  parameter int TEMP_W      = 8,
  parameter int CLK_MHZ     = 10,
  parameter int RAMP_US     = 50,
  parameter int FULL_MA     = 2000,
  parameter int HOT_START_C = 100,
  parameter int PCT_PER_C   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              suspend,
  input logic [TEMP_W-1:0] die_temp_c,
  input logic [2:0]        src_sel,
  input logic [LIM_W-1:0]  ilim_ma
);
  localparam int RAMP_CYC  = (CLK_MHZ * RAMP_US < 1) ? 1 : CLK_MHZ * RAMP_US;
  localparam int RAMP_RAW  = (FULL_MA + RAMP_CYC - 1) / RAMP_CYC;
  localparam int RAMP_STEP = (RAMP_RAW < 1) ? 1 : RAMP_RAW;
  localparam int HOT_END_C = HOT_START_C + (100 + PCT_PER_C - 1) / PCT_PER_C;

  // R3: exactly one source indicated
  p_onehot_src_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(src_sel) == 1);

  // R4: battery-only means no input current
  p_bat_zero_r4: assert property (@(posedge clk) disable iff (rst)
    src_sel[0] |-> (ilim_ma == '0));

  // R5: rising slew bounded by the step
  p_ramp_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ilim_ma > $past(ilim_ma)) |-> ((ilim_ma - $past(ilim_ma)) <= LIM_W'(RAMP_STEP)));

  // R6: selection leaves an active source only at zero limit
  p_switch_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ((src_sel != $past(src_sel)) && !$past(src_sel[0]) && !$past(suspend))
      |-> ($past(ilim_ma) == '0));

  // R8: suspend forces zero and battery on the next edge
  p_suspend_off_r8: assert property (@(posedge clk) disable iff (rst)
    suspend |=> (ilim_ma == '0 && src_sel == 3'b001));

  // R9: at or above the cutoff temperature nothing is drawn
  p_hot_cutoff_r9: assert property (@(posedge clk) disable iff (rst)
    (die_temp_c >= TEMP_W'(HOT_END_C)) |=> (ilim_ma == '0));
endmodule

bind supply_source_sel srcsel_checker #(
  .LIM_W      (LIM_W),
  .TEMP_W     (TEMP_W),
  .CLK_MHZ    (CLK_MHZ),
  .RAMP_US    (RAMP_US),
  .FULL_MA    (FULL_MA),
  .HOT_START_C(HOT_START_C),
  .PCT_PER_C  (PCT_PER_C)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .suspend   (suspend),
  .die_temp_c(die_temp_c),
  .src_sel   (src_sel),
  .ilim_ma   (ilim_ma)
);

// File: tb/sim_supply_source_sel.sv
`timescale 1ns/1ps
module sim_supply_source_sel;
  localparam int CLK_PERIOD = 10;
  localparam int DEB       = 4;
  localparam int STEP      = 40;  // ceil(2000 / (1*50))
  localparam logic [2:0] S_BAT = 3'b001;
  localparam logic [2:0] S_USB = 3'b010;
  localparam logic [2:0] S_DC  = 3'b100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] dc_mv = '0;
  logic [15:0] usb_mv = '0;
  logic        dc_prog_mode = 1'b0;
  logic        usb_lim_hi = 1'b1;
  logic [11:0] prog_lim_ma = 12'd1500;
  logic        suspend = 1'b0;
  logic [7:0]  die_temp_c = 8'd25;
  logic        dc_ok, usb_ok;
  logic [2:0]  src_sel;
  logic [11:0] ilim_ma;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_source_sel #(
    .DEB_LEN(DEB),
    .CLK_MHZ(1),
    .RAMP_US(50)
  ) u0 (
    .clk(clk), .rst(rst), .dc_mv(dc_mv), .usb_mv(usb_mv),
    .dc_prog_mode(dc_prog_mode), .usb_lim_hi(usb_lim_hi),
    .prog_lim_ma(prog_lim_ma), .suspend(suspend), .die_temp_c(die_temp_c),
    .dc_ok(dc_ok), .usb_ok(usb_ok), .src_sel(src_sel), .ilim_ma(ilim_ma)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs until src/limit match, watching slew and switch-at-zero.
  task automatic wait_state(input logic [2:0] es, input int el, input int maxc, input string req);
    logic [2:0]  ps;
    logic [11:0] pl;
    int worst_up = 0;
    int bad_sw   = 0;
    int n        = 0;
    ps = src_sel;
    pl = ilim_ma;
    while (!(src_sel == es && ilim_ma == el) && n < maxc) begin
      tick(1);
      n++;
      if (ilim_ma > pl && int'(ilim_ma - pl) > worst_up) worst_up = int'(ilim_ma - pl);
      if (src_sel != ps && ps != S_BAT && pl != 0) bad_sw++;
      ps = src_sel;
      pl = ilim_ma;
    end
    check(src_sel == es, {req, " source"}, src_sel, es);
    check(ilim_ma == el, {req, " limit"}, ilim_ma, el);
    check(worst_up <= STEP, "R5 step", worst_up, STEP);
    check(bad_sw == 0, "R6 switch at zero", bad_sw, 0);
  endtask

  task automatic t_reset();
    tick(3);
    rst = 1'b0;
    check(dc_ok == 1'b0,  "R10 dc_ok", dc_ok, 0);
    check(usb_ok == 1'b0, "R10 usb_ok", usb_ok, 0);
    check(src_sel == S_BAT, "R10 src", src_sel, S_BAT);
    check(ilim_ma == 0, "R10 ilim", ilim_ma, 0);
  endtask

  task automatic t_usb_window();
    usb_mv = 16'd4100;                 // on the edge: not valid
    tick(DEB + 2);
    check(usb_ok == 1'b0, "R1 4100 edge", usb_ok, 0);
    usb_mv = 16'd5000;                 // two-sample glitch
    tick(2);
    usb_mv = 16'd0;
    tick(DEB + 2);
    check(usb_ok == 1'b0, "R1 glitch", usb_ok, 0);
    usb_mv = 16'd4101;
    tick(DEB - 1);
    check(usb_ok == 1'b0, "R1 before N", usb_ok, 0);
    tick(1);
    check(usb_ok == 1'b1, "R1 at N", usb_ok, 1);
    usb_mv = 16'd6600;
    tick(DEB);
    check(usb_ok == 1'b0, "R1 6600 edge", usb_ok, 0);
    usb_mv = 16'd5000;
    tick(DEB);
    check(usb_ok == 1'b1, "R1 recover", usb_ok, 1);
  endtask

  task automatic t_usb_limits();
    usb_lim_hi = 1'b1;
    wait_state(S_USB, 500, 200, "R7 usb 500");
    usb_lim_hi = 1'b0;
    wait_state(S_USB, 100, 200, "R7 usb 100");
    usb_lim_hi = 1'b1;
    wait_state(S_USB, 500, 200, "R5 usb back to 500");
  endtask

  task automatic t_dc_takeover();
    dc_mv = 16'd4300;                  // valid alone, not with USB
    tick(DEB + 4);
    check(dc_ok == 1'b0, "R2 4300 with usb", dc_ok, 0);
    dc_mv = 16'd4450;
    tick(DEB + 4);
    check(dc_ok == 1'b0, "R2 4450 edge", dc_ok, 0);
    check(src_sel == S_USB, "R3 usb kept", src_sel, S_USB);
    dc_mv = 16'd4451;
    tick(DEB);
    check(dc_ok == 1'b1, "R2 4451", dc_ok, 1);
    wait_state(S_DC, 500, 200, "R6 dc takeover");
  endtask

  task automatic t_dc_limits();
    dc_prog_mode = 1'b1;
    prog_lim_ma  = 12'd1500;
    wait_state(S_DC, 1500, 200, "R7 prog 1500");
    prog_lim_ma = 12'd3000;
    wait_state(S_DC, 2000, 200, "R7 clamp high");
    prog_lim_ma = 12'd200;
    wait_state(S_DC, 500, 200, "R7 clamp low");
    dc_prog_mode = 1'b0;
    usb_lim_hi   = 1'b0;
    wait_state(S_DC, 100, 200, "R7 dc usb-mode 100");
    usb_lim_hi   = 1'b1;
    dc_prog_mode = 1'b1;
    prog_lim_ma  = 12'd2000;
    wait_state(S_DC, 2000, 200, "R7 prog 2000");
  endtask

  task automatic t_thermal();
    die_temp_c = 8'd100;
    tick(3);
    check(ilim_ma == 2000, "R9 at 100C", ilim_ma, 2000);
    die_temp_c = 8'd110;               // 50 percent
    wait_state(S_DC, 1000, 200, "R9 110C");
    die_temp_c = 8'd119;               // 5 percent
    wait_state(S_DC, 100, 200, "R9 119C");
    die_temp_c = 8'd120;
    tick(1);
    check(ilim_ma == 0, "R9 120C cutoff", ilim_ma, 0);
    die_temp_c = 8'd25;
    wait_state(S_DC, 2000, 200, "R9 cooled");
  endtask

  task automatic t_suspend();
    suspend = 1'b1;
    tick(1);
    check(ilim_ma == 0, "R8 limit zero", ilim_ma, 0);
    check(src_sel == S_BAT, "R8 battery", src_sel, S_BAT);
    usb_mv = 16'd0;
    tick(DEB);
    check(usb_ok == 1'b0, "R8 usb flag tracks", usb_ok, 0);
    check(dc_ok == 1'b1, "R8 dc flag holds", dc_ok, 1);
    check(ilim_ma == 0, "R8 still zero", ilim_ma, 0);
    suspend = 1'b0;
    wait_state(S_DC, 2000, 200, "R8 resume");
  endtask

  task automatic t_removal();
    dc_mv = 16'd16000;
    tick(DEB);
    check(dc_ok == 1'b0, "R2 16000 edge", dc_ok, 0);
    wait_state(S_BAT, 0, 200, "R4 to battery");
    dc_mv = 16'd4200;                  // valid with no USB
    tick(DEB);
    check(dc_ok == 1'b1, "R2 4200 alone", dc_ok, 1);
    wait_state(S_DC, 2000, 200, "R2 dc alone");
    dc_mv  = 16'd5000;
    usb_mv = 16'd5000;
    tick(DEB + 6);
    check(usb_ok == 1'b1, "R3 usb valid too", usb_ok, 1);
    check(src_sel == S_DC, "R3 dc priority", src_sel, S_DC);
    check(ilim_ma == 2000, "R3 dc limit kept", ilim_ma, 2000);
    dc_mv = 16'd0;
    wait_state(S_USB, 500, 200, "R6 dc to usb");
    usb_mv = 16'd0;
    wait_state(S_BAT, 0, 200, "R4 all gone");
  endtask

  initial begin
    t_reset();
    t_usb_window();
    t_usb_limits();
    t_dc_takeover();
    t_dc_limits();
    t_thermal();
    t_suspend();
    t_removal();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule